// File: doc/BRIEF.md
# Ripple-Carry Integer ALU with Set-Less-Than

This block is a purely combinational integer arithmetic logic unit of parameterised width (32 bits by default). It is built as a chain of identical one-bit cells. Each cell holds a full adder, an AND gate, an OR gate and a four-way output selector. A 3-bit operation code selects bitwise AND, bitwise OR, addition, subtraction or set-less-than. The block drives the result word together with zero, signed-overflow and carry flags.

Subtraction reuses the adder. B is inverted and the carry into bit 0 is forced high, so the chain computes A + ~B + 1. Set-less-than runs the same subtraction. It then routes the sign bit of the top cell's sum back to the lowest cell, which places that bit in position 0 of the result. Every other position reads 0. The block is meant to sit in the execute stage of a simple datapath, with operands and an operation code already decoded upstream.

Top module: `rc_alu`

## Requirements
- R1: Opcode 3'b000 gives result = A AND B, bit by bit.
- R2: Opcode 3'b001 gives result = A OR B, bit by bit.
- R3: Opcode 3'b010 gives result = (A + B) modulo 2^WIDTH. The carry flag is the carry out of the most significant bit.
- R4: Opcode 3'b110 gives result = (A - B) modulo 2^WIDTH, formed as A + ~B + 1. The carry flag is the carry out of that sum, which is 1 exactly when A >= B as unsigned values.
- R5: Opcode 3'b111 gives a result whose bit 0 is the sign bit (bit WIDTH-1) of the wrapped difference A - B, with all other bits 0. No overflow correction is applied. For example, A = 0x80000000 and B = 1 yields 0.
- R6: For opcodes 3'b010 and 3'b110, the overflow flag is 1 exactly when the true signed two's-complement result lies outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1.
- R7: The zero flag is 1 exactly when every bit of the result is 0.
- R8: For opcodes 3'b000, 3'b001 and 3'b111, the overflow and carry flags are both 0.
- R9: Opcodes 3'b011, 3'b100 and 3'b101 give a result of 0, zero flag 1, overflow 0 and carry 0, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 3 | Operation code |
| result_o | output | WIDTH | Result word |
| zero_o | output | 1 | Result is all zeros |
| overflow_o | output | 1 | Signed overflow of add or subtract |
| carry_o | output | 1 | Carry out of the top cell for add or subtract |

## Verification
The in-design assertions compare the cell chain against independent word-level arithmetic whenever the inputs are known. They cover the AND, OR, sum and difference results and the single-bit form of set-less-than. They check the overflow flag against an operand-sign rule instead of the carry pair that drives it. They also check the silent flags for the logic operations and the all-zero output for unused codes. Some behaviours need the bench's scenarios: the exact value set-less-than produces at the extreme operands where the raw sign bit is wrong, the zero flag on wrapping sums, and the carry at the A = B subtraction boundary.

// File: rtl/alu_rc_pkg.sv
package alu_rc_pkg;

  localparam logic [2:0] OPC_AND = 3'b000;
  localparam logic [2:0] OPC_OR  = 3'b001;
  localparam logic [2:0] OPC_ADD = 3'b010;
  localparam logic [2:0] OPC_SUB = 3'b110;
  localparam logic [2:0] OPC_SLT = 3'b111;

  // per-cell output selector, order fixed by the lower two opcode bits
  typedef enum logic [1:0] {
    PICK_AND  = 2'd0,
    PICK_OR   = 2'd1,
    PICK_SUM  = 2'd2,
    PICK_LESS = 2'd3
  } cell_pick_e;

  typedef struct packed {
    logic       flip_b;
    logic       seed_carry;
    cell_pick_e pick;
    logic       arith;
    logic       legal;
  } cell_ctrl_t;

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

  // overflow judged from operand and result signs
  function automatic logic sign_rule_ovf(input logic xs, input logic ys, input logic ss);
    return (xs == ys) && (ss != xs);
  endfunction

  function automatic logic opcode_known(input logic [2:0] op);
    return (op == OPC_AND) || (op == OPC_OR) || (op == OPC_ADD) ||
           (op == OPC_SUB) || (op == OPC_SLT);
  endfunction

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_rc_pkg::*;
(
  input  logic [2:0] op_i,
  output cell_ctrl_t ctrl_o
);
  logic known;

  always_comb begin
    known             = opcode_known(op_i);
    ctrl_o.flip_b     = op_i[2];
    ctrl_o.seed_carry = op_i[2];
    ctrl_o.pick       = cell_pick_e'(op_i[1:0]);
    ctrl_o.legal      = known;
    ctrl_o.arith      = known && (op_i[1:0] == 2'd2);
  end
endmodule

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
  import alu_rc_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       flip_b_i,
  input  logic       carry_i,
  input  cell_pick_e pick_i,
  input  logic       less_i,
  output logic       sum_o,
  output logic       carry_o,
  output logic       out_o
);
  logic b_eff;

  always_comb begin
    b_eff   = b_i ^ flip_b_i;
    sum_o   = fa_sum(a_i, b_eff, carry_i);
    carry_o = fa_carry(a_i, b_eff, carry_i);
    unique case (pick_i)
      PICK_AND:  out_o = a_i & b_eff;
      PICK_OR:   out_o = a_i | b_eff;
      PICK_SUM:  out_o = sum_o;
      PICK_LESS: out_o = less_i;
      default:   out_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] word_i,
  input  logic             legal_i,
  input  logic             arith_i,
  input  logic             msb_carry_in_i,
  input  logic             msb_carry_out_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o,
  output logic             carry_o
);
  always_comb begin
    result_o   = legal_i ? word_i : '0;
    zero_o     = ~|result_o;
    overflow_o = arith_i & (msb_carry_in_i ^ msb_carry_out_i);
    carry_o    = arith_i & msb_carry_out_i;
  end
endmodule

// File: rtl/rc_alu.sv
module rc_alu
  import alu_rc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o,
  output logic             carry_o
);
  localparam int TOP = WIDTH - 1;

  cell_ctrl_t       ctrl;
  logic [WIDTH-1:0] chain_word;
  logic             top_sum;
  logic             top_cin;
  logic             top_cout;

  alu_op_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : stage
    logic cin, cout, s, r, less;
    if (i == 0) begin : g_first
      assign cin  = ctrl.seed_carry;
      assign less = top_sum;
    end else begin : g_rest
      assign cin  = stage[i-1].cout;
      assign less = 1'b0;
    end

    alu_bit_cell u_cell (
      .a_i      (a_i[i]),
      .b_i      (b_i[i]),
      .flip_b_i (ctrl.flip_b),
      .carry_i  (cin),
      .pick_i   (ctrl.pick),
      .less_i   (less),
      .sum_o    (s),
      .carry_o  (cout),
      .out_o    (r)
    );

    assign chain_word[i] = r;

    if (i == TOP) begin : g_last
      assign top_sum  = s;
      assign top_cin  = cin;
      assign top_cout = cout;
    end
  end

  alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
    .word_i          (chain_word),
    .legal_i         (ctrl.legal),
    .arith_i         (ctrl.arith),
    .msb_carry_in_i  (top_cin),
    .msb_carry_out_i (top_cout),
    .result_o        (result_o),
    .zero_o          (zero_o),
    .overflow_o      (overflow_o),
    .carry_o         (carry_o)
  );

  // independent word-level views used only by the checks below
  logic [WIDTH:0]   ref_add;
  logic [WIDTH-1:0] ref_diff;
  logic             inputs_known;

  assign ref_add      = {1'b0, a_i} + {1'b0, b_i};
  assign ref_diff     = a_i - b_i;
  assign inputs_known = !$isunknown({a_i, b_i, op_i});

  always_comb begin
    if (inputs_known) begin
      if (op_i == OPC_AND)
        AST_AND_WORD: assert (result_o == (a_i & b_i)) else $error("and word mismatch"); // R1
      if (op_i == OPC_OR)
        AST_OR_WORD: assert (result_o == (a_i | b_i)) else $error("or word mismatch"); // R2
      if (op_i == OPC_ADD)
        AST_ADD_WORD: assert ({carry_o, result_o} == ref_add) else $error("add mismatch"); // R3
      if (op_i == OPC_SUB)
        AST_SUB_WORD: assert (result_o == ref_diff && carry_o == (a_i >= b_i)) else $error("sub mismatch"); // R4
      if (op_i == OPC_SLT)
        AST_SLT_FORM: assert (result_o == {{(WIDTH-1){1'b0}}, ref_diff[TOP]}) else $error("slt form"); // R5
      if (op_i == OPC_ADD)
        AST_OVF_ADD: assert (overflow_o == sign_rule_ovf(a_i[TOP], b_i[TOP], result_o[TOP])) else $error("add ovf"); // R6
      if (op_i == OPC_SUB)
        AST_OVF_SUB: assert (overflow_o == sign_rule_ovf(a_i[TOP], ~b_i[TOP], result_o[TOP])) else $error("sub ovf"); // R6
      if (op_i == OPC_AND || op_i == OPC_OR || op_i == OPC_SLT)
        AST_QUIET_FLAGS: assert (!overflow_o && !carry_o) else $error("flags not quiet"); // R8
      if (!opcode_known(op_i))
        AST_UNUSED_CODE: assert (result_o == '0 && zero_o && !overflow_o && !carry_o) else $error("unused code"); // R9
    end
  end
endmodule

// File: tb/sim_rc_alu.sv
module sim_rc_alu;
  localparam int W = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst;

  logic [W-1:0] a, b;
  logic [2:0]   op;
  logic [W-1:0] res;
  logic         zf, vf, cf;

  rc_alu #(.WIDTH(W)) u0 (
    .a_i(a), .b_i(b), .op_i(op),
    .result_o(res), .zero_o(zf), .overflow_o(vf), .carry_o(cf)
  );

  typedef struct {
    logic [W-1:0] r;
    logic         z, v, c;
    string        req;
  } item_t;

  item_t sb[$];
  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3/R6";
      3'b110:  return "R4/R6";
      3'b111:  return "R5/R8";
      default: return "R9";
    endcase
  endfunction

  function automatic item_t model(input logic [W-1:0] x, input logic [W-1:0] y,
                                  input logic [2:0] o, input string req);
    item_t  it;
    longint sx, sy, s;
    longint hi, lo;
    logic [W:0] wide;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    hi = (longint'(1) <<< (W - 1)) - 1;
    lo = -(longint'(1) <<< (W - 1));
    it.r = '0; it.v = 1'b0; it.c = 1'b0; it.req = req;
    case (o)
      3'b000: it.r = x & y;
      3'b001: it.r = x | y;
      3'b010: begin
        wide = {1'b0, x} + {1'b0, y};
        it.r = wide[W-1:0];
        it.c = wide[W];
        s    = sx + sy;
        it.v = (s > hi) || (s < lo);
      end
      3'b110: begin
        it.r = x - y;
        it.c = (x >= y);
        s    = sx - sy;
        it.v = (s > hi) || (s < lo);
      end
      3'b111: begin
        wide = {1'b0, x - y};
        it.r = {{(W-1){1'b0}}, wide[W-1]};
      end
      default: it.r = '0;
    endcase
    it.z = (it.r == '0);
    return it;
  endfunction

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [2:0] o, input string req);
    @(posedge clk);
    #1;
    a = x; b = y; op = o;
    sb.push_back(model(x, y, o, req));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // monitor: compares at the falling edge, four time units after the inputs settle
  always @(negedge clk) begin : mon
    item_t exp_it;
    if (!rst && sb.size() > 0) begin
      exp_it = sb.pop_front();
      total++;
      if (res !== exp_it.r || zf !== exp_it.z || vf !== exp_it.v || cf !== exp_it.c) begin
        fails++;
        $display("FAIL %s: got r=%h z=%b v=%b c=%b expected r=%h z=%b v=%b c=%b",
                 exp_it.req, res, zf, vf, cf, exp_it.r, exp_it.z, exp_it.v, exp_it.c);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; a = '0; b = '0; op = 3'b000;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state with zero inputs: AND of zeros, zero flag set (R7)
    drive('0, '0, 3'b000, "R7 idle");
    drive(32'hF0F0_A5A5, 32'h0FF0_FF00, 3'b000, "R1");
    drive(32'hF0F0_0000, 32'h0F0F_FFFF, 3'b000, "R1/R7 disjoint");
    drive(32'hF000_0001, 32'h0000_1230, 3'b001, "R2");
    drive('0, '0, 3'b001, "R2/R7");
    drive(32'd1234, 32'd4321, 3'b010, "R3");
    drive(32'hFFFF_FFFF, 32'd1, 3'b010, "R3/R7 wrap carry");
    drive(32'h7FFF_FFFF, 32'd1, 3'b010, "R6 add pos ovf");
    drive(32'h8000_0000, 32'h8000_0000, 3'b010, "R6/R7 add neg ovf");
    drive(32'd5, 32'd5, 3'b110, "R4/R7 equal");
    drive(32'd3, 32'd5, 3'b110, "R4 borrow");
    drive(32'd0, 32'd0, 3'b110, "R4 zero minus zero");
    drive(32'h8000_0000, 32'd1, 3'b110, "R6 sub ovf");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110, "R6 sub ovf pos");
    drive(32'd3, 32'd5, 3'b111, "R5 less");
    drive(32'd5, 32'd3, 3'b111, "R5 greater");
    drive(32'hFFFF_FFFF, 32'd1, 3'b111, "R5 neg vs pos");
    drive(32'd7, 32'd7, 3'b111, "R5/R8 equal");
    drive(32'h8000_0000, 32'd1, 3'b111, "R5 extreme min vs 1");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111, "R5 extreme max vs -1");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011, "R9 op011");
    drive(32'h1234_5678, 32'h8765_4321, 3'b100, "R9 op100");
    drive(32'h8000_0000, 32'h8000_0000, 3'b101, "R9 op101");
    for (int k = 0; k < 48; k++) begin
      logic [2:0] o;
      o = 3'(k % 8);
      drive($urandom, $urandom, o, req_of(o));
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule